// File: doc/BRIEF.md
# Three-Phase Bridge Gate Controller

This block turns the switch requests of a six-step commutation sequencer into six gate drive levels for a three-phase half bridge. Each phase has a high-side drive, active low, and a low-side drive, active high. A PWM/current-limit enable chops the low-side drives. A brake input turns every low-side switch on and every high-side switch off. An undervoltage lockout shuts off all six drives and pulls a fault flag low.

The block delays any low-side turn-on until a digital feedback signal shows that the same phase's high-side switch has actually stopped conducting. This stops shoot-through when the sequencer moves out of the alignment step, where phase C is driven high, into the first run step, where phase C is driven low. A counter flags a fault if a hold-off lasts too long.

The undervoltage detector supplies two flags: a trip flag and a clear flag. The clear flag sits a margin above the trip level, and this gap gives the lockout its hysteresis. The brake and undervoltage inputs are asynchronous to the block's clock.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: After reset the block starts in lockout. All high-side drives are high (off), all low-side drives are low (off), uv_fault_n is low, and fb_fault is low.
- R2: In run mode each high-side drive is the inverse of its request bit, one clock edge after the request. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C on every three-bit port.
- R3: In run mode a low-side drive is on only while pwm_en is high. pwm_en never changes a high-side drive.
- R4: A low-side drive turns on only if its same-phase high-side feedback read low at the previous clock edge. When the feedback clears, the held drive turns on one edge later. This covers the move from alignment (high requests A and C, low request B) to the first run step (high request A, low request C).
- R5: brake_req passes through a two-flop synchroniser and acts on the third edge after it is set. In brake mode all high-side drives are off, and each low-side drive is on whenever its feedback is low. pwm_en is ignored in brake mode.
- R6: uv_trip passes through a two-flop synchroniser. uv_fault_n goes low three edges after uv_trip is set, and all six drives are off one edge after that. The lockout overrides brake and run mode.
- R7: The lockout releases only when uv_clear is high and uv_trip is low. When both are low, the lockout state is kept.
- R8: fb_fault rises after HOLD_LIMIT consecutive edges in which some phase wants its low side on but its feedback holds it off. A shorter wait does not raise it. Once set, fb_fault stays high until reset.
- R9: A phase never has both its drives on at the outputs. In run mode, if both requests of a phase are set, the high side is driven and the low side stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_req | input | 3 | High-side switch requests from the sequencer, 1 = on |
| lo_req | input | 3 | Low-side switch requests from the sequencer, 1 = on |
| pwm_en | input | 1 | PWM and current-limit enable for the low-side drives |
| brake_req | input | 1 | Brake command, 1 = brake, asynchronous |
| uv_trip | input | 1 | Supply is below the trip level, asynchronous |
| uv_clear | input | 1 | Supply is above the release level, asynchronous |
| hi_fb | input | 3 | High-side conduction feedback, 1 = still on |
| hi_n | output | 3 | High-side gate drives, active low |
| lo | output | 3 | Low-side gate drives, active high |
| uv_fault_n | output | 1 | Undervoltage lockout flag, active low |
| fb_fault | output | 1 | Sticky high-side feedback timeout flag |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is brake and current limiting. The bench asserts brake while pwm_en is low. It expects all three low-side drives on, because the brake must win over the current-limit chop.

The second pair is brake and undervoltage. The bench raises brake_req and uv_trip on the same edge. It expects all six drives off and the fault flag low, because the lockout ranks above brake.

Random runs hold each input pattern for several cycles and compare the drives with a priority model written in the bench.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;
    localparam int unsigned N_PH = 3;

    typedef logic [N_PH-1:0] ph_vec_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_LOCK  = 2'd2
    } gate_mode_e;

    typedef struct packed {
        logic    lockout;
        ph_vec_t hi_n;
        ph_vec_t lo;
    } gate_state_t;
endpackage

// File: rtl/bg_sync2.sv
module bg_sync2 #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // One two-flop chain per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, meta_d;
        logic stab_q, stab_d;

        always_comb begin
            meta_d = async_i[b];
            stab_d = meta_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= meta_d;
                stab_q <= stab_d;
            end
        end

        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/bg_phase_guard.sv
module bg_phase_guard #(
    parameter int unsigned HOLD_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_lo_i,
    input  logic hi_fb_i,
    output logic lo_ok_o,
    output logic fault_o
);
    localparam int unsigned CW     = $clog2(HOLD_LIMIT + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(HOLD_LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fault;
    } guard_t;

    guard_t g_d, g_q;
    logic   blocked;

    always_comb begin
        blocked = want_lo_i && hi_fb_i;
        lo_ok_o = want_lo_i && !hi_fb_i;
        g_d     = g_q;
        if (blocked) begin
            if (g_q.cnt == LIM_M1) begin
                g_d.fault = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end else begin
            g_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign fault_o = g_q.fault;

    // R8: the timeout flag is sticky
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.fault |=> g_q.fault);

    // R8: the wait counter never passes its limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= LIM_M1);

    // R8: an unblocked edge restarts the wait count
    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !blocked |=> (g_q.cnt == '0));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
    import bridge_gate_pkg::*;
#(
    parameter int unsigned HOLD_LIMIT = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hi_req,
    input  logic [2:0] lo_req,
    input  logic       pwm_en,
    input  logic       brake_req,
    input  logic       uv_trip,
    input  logic       uv_clear,
    input  logic [2:0] hi_fb,
    output logic [2:0] hi_n,
    output logic [2:0] lo,
    output logic       uv_fault_n,
    output logic       fb_fault
);
    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] sync_s;
    logic              brake_s, uv_trip_s, uv_clear_s;
    gate_state_t       st_d, st_q;
    gate_mode_e        mode;
    ph_vec_t           want_lo, lo_ok, ph_fault;

    bg_sync2 #(.WIDTH(N_SYNC)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({brake_req, uv_trip, uv_clear}),
        .sync_o  (sync_s)
    );

    assign {brake_s, uv_trip_s, uv_clear_s} = sync_s;

    // Priority: lockout, then brake, then run mode.
    always_comb begin
        if (st_q.lockout)  mode = MODE_LOCK;
        else if (brake_s)  mode = MODE_BRAKE;
        else               mode = MODE_RUN;
    end

    always_comb begin
        unique case (mode)
            MODE_LOCK:  want_lo = '0;
            MODE_BRAKE: want_lo = '1;
            default:    want_lo = lo_req & ~hi_req & {N_PH{pwm_en}};
        endcase
    end

    for (genvar p = 0; p < N_PH; p++) begin : g_ph
        bg_phase_guard #(.HOLD_LIMIT(HOLD_LIMIT)) i_guard (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_lo_i (want_lo[p]),
            .hi_fb_i   (hi_fb[p]),
            .lo_ok_o   (lo_ok[p]),
            .fault_o   (ph_fault[p])
        );

        // R9: never both drives of one phase on together
        p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(lo[p] && !hi_n[p]));

        // R4: a low side comes on only after its feedback read off
        p_lo_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo[p]) |-> !$past(hi_fb[p]));
    end

    always_comb begin
        st_d = st_q;
        if (uv_trip_s)       st_d.lockout = 1'b1;
        else if (uv_clear_s) st_d.lockout = 1'b0;

        st_d.hi_n = (mode == MODE_RUN) ? ~hi_req : '1;
        st_d.lo   = lo_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lockout <= 1'b1;
            st_q.hi_n    <= '1;
            st_q.lo      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_n       = st_q.hi_n;
    assign lo         = st_q.lo;
    assign uv_fault_n = !st_q.lockout;
    assign fb_fault   = |ph_fault;

    // R6: a lockout turns every drive off on the next edge
    p_lock_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lockout |=> (lo == 3'b000 && hi_n == 3'b111));

    // R5: brake turns off all high sides
    p_brake_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_s && !st_q.lockout) |=> (hi_n == 3'b111));

    // R7: without a clear flag the lockout holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lockout && !uv_clear_s) |=> st_q.lockout);

    // R3: with the enable low no low side is driven in run mode
    p_pwm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && !pwm_en) |=> (lo == 3'b000));
endmodule

// File: tb/test_bridge_gate_ctrl.sv
module test_bridge_gate_ctrl;
    localparam int unsigned LIM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hi_req = '0, lo_req = '0, hi_fb = '0;
    logic       pwm_en = 1'b0, brake_req = 1'b0, uv_trip = 1'b0, uv_clear = 1'b0;
    logic [2:0] hi_n, lo;
    logic       uv_fault_n, fb_fault;

    int checks = 0;
    int failures = 0;
    logic lk_m = 1'b1;

    always #5 clk = ~clk;

    bridge_gate_ctrl #(.HOLD_LIMIT(LIM)) i_bridge_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
        .pwm_en(pwm_en), .brake_req(brake_req), .uv_trip(uv_trip),
        .uv_clear(uv_clear), .hi_fb(hi_fb), .hi_n(hi_n), .lo(lo),
        .uv_fault_n(uv_fault_n), .fb_fault(fb_fault)
    );

    function automatic logic [2:0] exp_lo(logic lk, logic brk, logic [2:0] hr,
                                          logic [2:0] lr, logic pe, logic [2:0] fb);
        if (lk)  return 3'b000;
        if (brk) return ~fb;
        return lr & ~hr & {3{pe}} & ~fb;
    endfunction

    function automatic logic [2:0] exp_hi_n(logic lk, logic brk, logic [2:0] hr);
        return (lk || brk) ? 3'b111 : ~hr;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        chk(req, {2'b0, hi_n, lo}, {2'b0, exp_hi_n(lk_m, brake_req, hi_req),
            exp_lo(lk_m, brake_req, hi_req, lo_req, pwm_en, hi_fb)});
        chk(req, {7'b0, uv_fault_n}, {7'b0, !lk_m});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        lk_m = 1'b1;
    endtask

    task automatic release_uv();
        uv_trip = 1'b0;
        uv_clear = 1'b1;
        edges(6);
        lk_m = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4425));
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1", {2'b0, hi_n, lo}, {2'b0, 3'b111, 3'b000});
        chk("R1", {6'b0, uv_fault_n, fb_fault}, 8'h00);
        edges(5);
        chk("R1 lockout kept with no clear flag", {7'b0, uv_fault_n}, 8'h00);

        release_uv();
        chk("R7 release", {7'b0, uv_fault_n}, 8'h01);

        // R2: polarity and latency
        hi_req = 3'b010; lo_req = 3'b000; pwm_en = 1'b1;
        edges(1);
        chk("R2", {5'b0, hi_n}, {5'b0, 3'b101});

        // R3: pwm_en gates low sides only
        hi_req = 3'b001; lo_req = 3'b100; pwm_en = 1'b0;
        edges(1);
        chk("R3 chopped", {2'b0, hi_n, lo}, {2'b0, 3'b110, 3'b000});
        pwm_en = 1'b1;
        edges(1);
        chk("R3 enabled", {2'b0, hi_n, lo}, {2'b0, 3'b110, 3'b100});

        // R9: conflicting request on one phase
        hi_req = 3'b100; lo_req = 3'b100;
        edges(1);
        chk("R9", {2'b0, hi_n, lo}, {2'b0, 3'b011, 3'b000});

        // R4: align step then first run step, phase C feedback lags
        hi_req = 3'b101; lo_req = 3'b010; hi_fb = 3'b101;
        edges(2);
        chk("R4 align", {2'b0, hi_n, lo}, {2'b0, 3'b010, 3'b010});
        hi_req = 3'b001; lo_req = 3'b100;
        edges(3);
        chk("R4 held", {5'b0, lo}, {5'b0, 3'b000});
        hi_fb = 3'b001;
        edges(1);
        chk("R4 released", {2'b0, hi_n, lo}, {2'b0, 3'b110, 3'b100});

        // R5: brake latency, and brake with pwm_en low
        hi_fb = 3'b000; pwm_en = 1'b0; brake_req = 1'b1;
        edges(2);
        chk("R5 not yet", {5'b0, hi_n}, {5'b0, 3'b110});
        edges(1);
        chk("R5 brake over current limit", {2'b0, hi_n, lo}, {2'b0, 3'b111, 3'b111});
        brake_req = 1'b0;
        edges(4);

        // R6: brake and undervoltage trip together
        uv_clear = 1'b0; pwm_en = 1'b1; brake_req = 1'b1; uv_trip = 1'b1;
        edges(3);
        chk("R6 flag", {7'b0, uv_fault_n}, 8'h00);
        edges(1);
        chk("R6 all off", {2'b0, hi_n, lo}, {2'b0, 3'b111, 3'b000});

        // R7: hysteresis, both flags low keeps lockout
        uv_trip = 1'b0; brake_req = 1'b0;
        edges(6);
        chk("R7 hold", {2'b0, uv_fault_n, hi_n, lo}, {2'b0, 1'b0, 3'b111, 3'b000});
        release_uv();
        chk("R7 after clear", {7'b0, uv_fault_n}, 8'h01);

        // R8: a short wait does not raise the flag, a long one does
        hi_req = 3'b000; lo_req = 3'b001; pwm_en = 1'b1; hi_fb = 3'b001;
        edges(LIM - 1);
        hi_fb = 3'b000;
        edges(1);
        hi_fb = 3'b001;
        edges(LIM - 1);
        chk("R8 short", {7'b0, fb_fault}, 8'h00);
        edges(1);
        chk("R8 timeout", {7'b0, fb_fault}, 8'h01);
        hi_fb = 3'b000;
        edges(3);
        chk("R8 sticky", {7'b0, fb_fault}, 8'h01);

        // Random patterns against the model (R2 R3 R4 R5 R6 R7 R9)
        do_reset();
        release_uv();
        for (int i = 0; i < 80; i++) begin
            hi_req    = 3'($urandom);
            lo_req    = 3'($urandom);
            hi_fb     = 3'($urandom) & 3'($urandom);
            pwm_en    = 1'($urandom);
            brake_req = ($urandom % 4) == 0;
            uv_trip   = ($urandom % 8) == 0;
            uv_clear  = !uv_trip && (($urandom % 2) == 0);
            if (uv_trip)       lk_m = 1'b1;
            else if (uv_clear) lk_m = 1'b0;
            edges(6);
            check_all("R2 R3 R4 R5 R6 R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule